// File: doc/BRIEF.md
# Flash Write Completion Poller

This block runs on the host side of a parallel flash. Once a requester has finished sending a program or erase command sequence, including its final write strobe, it pulses `start_i`. The poller then finds out when the flash has finished the operation. In data-bit mode it issues repeated read cycles to one address over a simple request/acknowledge bus and watches a single status bit of each returned word. A hit is only believed after two more reads of the same location agree with it, so a word sampled at the instant the flash finishes cannot fool it. In ready mode it watches the synchronized open-drain ready/busy line instead and issues no status reads.

After completion is confirmed in data-bit mode, the poller waits a settling interval, held as a parameter, before it trusts the whole word. It then performs one last read and hands the word back with a one-cycle `done_o` pulse. A single down-counter is loaded with the requester's timeout at start. If completion is never confirmed before the counter runs out, the poller ends with a one-cycle `error_o` pulse.

States: IDLE (waits for start), READ (first status read), CONF1 and CONF2 (the two confirmation reads), WAIT_RDY (waits for ready), SETTLE (settling wait), FETCH (final full-word read), DONE (done pulse), FAIL (error pulse). Transitions: IDLE→READ or IDLE→WAIT_RDY on start, depending on the mode. READ→CONF1, CONF1→CONF2 and CONF2→SETTLE on a matching read. CONF1/CONF2→READ on a mismatching read. WAIT_RDY→FETCH on ready. SETTLE→FETCH when the interval ends. FETCH→DONE on acknowledge. READ/CONF1/CONF2/WAIT_RDY→FAIL on expiry. DONE/FAIL→IDLE.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle. `busy_o`, `rd_req_o`, `done_o` and `error_o` are all low.
- R2: The operation kind (`erase_i`), the expected status value (`exp_dq_i`) and the address (`addr_i`) are captured on the cycle `start_i` is accepted. Later changes to these inputs have no effect on the running operation.
- R3: In program mode (`erase_i`=0) a read counts as a hit when bit POLL_BIT (default 7) of `rd_data_i` equals the captured `exp_dq_i`.
- R4: In erase mode (`erase_i`=1) a read counts as a hit when bit POLL_BIT of `rd_data_i` is 1, whatever value `exp_dq_i` holds.
- R5: Completion needs three hits in a row. A miss on either confirmation read sends polling back to a fresh first read, so the number of reads issued matches the hit/miss sequence.
- R6: Every read request carries the captured address on `rd_addr_o`, and the address stays stable while a request is held.
- R7: After the third hit is acknowledged, no read is requested for SETTLE_CYC+1 cycles. The next read is the final fetch, and its word appears on `data_o` together with `done_o`.
- R8: In ready mode (`use_rdy_i`=1) no status reads are issued. `done_o` follows a rise of `ready_i` within 8 cycles, after one fetch read.
- R9: With timeout value N and no completion, `error_o` pulses on the (N+1)th cycle after start is accepted, and `done_o` stays low.
- R10: If the third hit is acknowledged on the same cycle the counter reaches zero, completion wins and the operation ends with `done_o`.
- R11: `done_o` and `error_o` are single-cycle pulses, never high together, and the block is idle on the next cycle. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| erase_i | input | 1 | 1 = erase completion rule, 0 = program rule |
| use_rdy_i | input | 1 | 1 = wait on ready/busy instead of status reads |
| exp_dq_i | input | 1 | Value of the polled bit in the written data |
| addr_i | input | AW | Address to poll |
| timeout_i | input | CW | Timeout in cycles |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |
| ready_i | input | 1 | Ready/busy line from the flash (high = ready), asynchronous |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle timeout pulse |
| data_o | output | DW | Word from the final fetch, valid with `done_o` |

## Verification
Two functions can act in the same cycle: the acknowledge of the third confirming read, and the timeout counter reaching zero. The bench provokes this with a responder that answers every other cycle with hits, and a timeout of 4, so the third acknowledge lands on the expiry cycle. It expects `done_o` and no `error_o`. The same stimulus with a timeout of 3 must give `error_o`, which shows that expiry still wins one cycle earlier.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_READ,
        ST_CONF1,
        ST_CONF2,
        ST_WAIT_RDY,
        ST_SETTLE,
        ST_FETCH,
        ST_DONE,
        ST_FAIL
    } fdp_state_e;
endpackage

// File: rtl/fdp_sync.sv
module fdp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fdp_downcnt.sv
module fdp_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load_i)            cnt_q <= val_i;
        else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fdp_hit.sv
module fdp_hit (
    input  logic dq_i,
    input  logic exp_i,
    input  logic erase_i,
    output logic hit_o
);
    // Erase: polled bit reads 1 when finished. Program: it reads back the written value.
    assign hit_o = erase_i ? dq_i : (dq_i == exp_i);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int POLL_BIT   = 7,
    parameter int CW         = 20,
    parameter int SETTLE_CYC = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic          use_rdy_i,
    input  logic          exp_dq_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] timeout_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic          ready_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o,
    output logic [DW-1:0] data_o
);
    localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE_CYC);

    fdp_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          erase_q;
    logic          exp_q;
    logic [DW-1:0] data_q;
    logic          hit_w;
    logic          ready_s;
    logic          cnt_load, cnt_dec, cnt_zero;
    logic [CW-1:0] cnt_val;
    logic          accept_w;

    assign accept_w = (state_q == ST_IDLE) && start_i;

    fdp_hit u_hit (
        .dq_i    (rd_data_i[POLL_BIT]),
        .exp_i   (exp_q),
        .erase_i (erase_q),
        .hit_o   (hit_w)
    );

    fdp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ready_i),
        .q_o   (ready_s)
    );

    assign cnt_load = accept_w || ((state_q == ST_CONF2) && rd_ack_i && hit_w);
    assign cnt_val  = (state_q == ST_IDLE) ? timeout_i : SETTLE_V;
    assign cnt_dec  = (state_q == ST_READ) || (state_q == ST_CONF1) ||
                      (state_q == ST_CONF2) || (state_q == ST_WAIT_RDY) ||
                      (state_q == ST_SETTLE);

    fdp_downcnt #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .dec_i  (cnt_dec),
        .zero_o (cnt_zero)
    );

    // Captured request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            erase_q <= 1'b0;
            exp_q   <= 1'b0;
        end else if (accept_w) begin
            addr_q  <= addr_i;
            erase_q <= erase_i;
            exp_q   <= exp_dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                data_q <= '0;
        else if (state_q == ST_FETCH && rd_ack_i)  data_q <= rd_data_i;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = use_rdy_i ? ST_WAIT_RDY : ST_READ;
            end
            ST_READ: begin
                if (cnt_zero)                state_d = ST_FAIL;
                else if (rd_ack_i && hit_w)  state_d = ST_CONF1;
            end
            ST_CONF1: begin
                if (cnt_zero)      state_d = ST_FAIL;
                else if (rd_ack_i) state_d = hit_w ? ST_CONF2 : ST_READ;
            end
            ST_CONF2: begin
                // A confirmed completion outranks a simultaneous expiry
                if (rd_ack_i && hit_w) state_d = ST_SETTLE;
                else if (cnt_zero)     state_d = ST_FAIL;
                else if (rd_ack_i)     state_d = ST_READ;
            end
            ST_WAIT_RDY: begin
                if (ready_s)       state_d = ST_FETCH;
                else if (cnt_zero) state_d = ST_FAIL;
            end
            ST_SETTLE: begin
                if (cnt_zero) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (rd_ack_i) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req_o = (state_q == ST_READ) || (state_q == ST_CONF1) ||
                   (state_q == ST_CONF2) || (state_q == ST_FETCH);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
        error_o  = (state_q == ST_FAIL);
    end

    assign rd_addr_o = addr_q;
    assign data_o    = data_q;
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          error_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) error_o |=> !error_o); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && error_o)); // R11
    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) (done_o || error_o) |=> !busy_o); // R11
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o)); // R6
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(start_i)); // R2
endmodule

bind flash_done_poller fdp_checker #(.AW(AW)) u_fdp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb_top;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int SET = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, erase_i = 1'b0, use_rdy_i = 1'b0, exp_dq_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] timeout_i = '0;
    logic          rd_req_o, rd_ack_i = 1'b0;
    logic [AW-1:0] rd_addr_o;
    logic [DW-1:0] rd_data_i = '0;
    logic          ready_i = 1'b0;
    logic          busy_o, done_o, error_o;
    logic [DW-1:0] data_o;

    int errors = 0, checks = 0, cyc = 0;
    logic [DW-1:0] resp [16];
    int ri = 0, nreads = 0, addr_bad = 0;
    int ack_edge [16];
    int seen_cyc [16];
    logic resp_en = 1'b0;
    logic [AW-1:0] exp_addr = '0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    flash_done_poller #(.AW(AW), .DW(DW), .CW(CW), .SETTLE_CYC(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
        .use_rdy_i(use_rdy_i), .exp_dq_i(exp_dq_i), .addr_i(addr_i),
        .timeout_i(timeout_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .ready_i(ready_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .data_o(data_o)
    );

    // Bus responder: answers a held request on the following cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (resp_en && rd_req_o) begin
                if (rd_addr_o != exp_addr) addr_bad++;
                rd_data_i = resp[ri];
                if (nreads < 16) begin
                    seen_cyc[nreads] = cyc;
                    ack_edge[nreads] = cyc + 1;
                end
                if (ri < 15) ri++;
                nreads++;
                rd_ack_i = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic load_resp(input logic [DW-1:0] w [8]);
        for (int i = 0; i < 16; i++) resp[i] = (i < 8) ? w[i] : w[7];
        ri = 0; nreads = 0; addr_bad = 0;
    endtask

    task automatic go(input logic er, input logic rdy, input logic ex,
                      input logic [AW-1:0] a, input int tmo);
        @(negedge clk);
        erase_i = er; use_rdy_i = rdy; exp_dq_i = ex; addr_i = a;
        timeout_i = CW'(tmo); exp_addr = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // scramble captured inputs after acceptance
        erase_i = ~er; exp_dq_i = ~ex; addr_i = ~a;
    endtask

    // waits for done/error; returns negedges counted and which one
    task automatic wait_end(input int lim, output int n, output int d, output int e);
        n = 0; d = 0; e = 0;
        while (n < lim && !done_o && !error_o) begin
            @(negedge clk);
            n++;
        end
        d = int'(done_o); e = int'(error_o);
    endtask

    task automatic t_reset;
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 req", int'(rd_req_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 error", int'(error_o), 0);
    endtask

    task automatic t_program_exp1;
        int n, d, e;
        logic [DW-1:0] w [8];
        w = '{16'h0000, 16'h0080, 16'h0000, 16'h0080, 16'h0080, 16'h0080, 16'h12A5, 16'h12A5};
        load_resp(w); resp_en = 1'b1;
        go(1'b0, 1'b0, 1'b1, 20'h0A5A5, 200);
        wait_end(300, n, d, e);
        chk("R3 done on program hit", d, 1);
        chk("R5 reads with conf1 miss", nreads, 7);
        chk("R7 fetched word", int'(data_o), 16'h12A5);
        chk("R6 address", addr_bad, 0);
        @(negedge clk);
        chk("R11 done one cycle", int'(done_o), 0);
        chk("R11 idle after done", int'(busy_o), 0);
    endtask

    task automatic t_erase;
        int n, d, e;
        logic [DW-1:0] w [8];
        w = '{16'h0000, 16'h00FF, 16'h00FF, 16'h007F, 16'h0080, 16'h0080, 16'h0080, 16'hFFFF};
        load_resp(w); resp_en = 1'b1;
        go(1'b1, 1'b0, 1'b0, 20'h00123, 200);
        wait_end(300, n, d, e);
        chk("R4 done on erase", d, 1);
        chk("R5 R2 reads with conf2 miss", nreads, 8);
        chk("R4 fetched word", int'(data_o), 16'hFFFF);
        chk("R2 R6 latched address", addr_bad, 0);
    endtask

    task automatic t_program_exp0;
        int n, d, e;
        logic [DW-1:0] w [8];
        w = '{16'h0080, 16'h0000, 16'h0000, 16'h0000, 16'h5555, 16'h5555, 16'h5555, 16'h5555};
        load_resp(w); resp_en = 1'b1;
        go(1'b0, 1'b0, 1'b0, 20'hFFFFF, 200);
        wait_end(300, n, d, e);
        chk("R3 done expecting 0", d, 1);
        chk("R3 reads", nreads, 5);
        chk("R7 settle gap", seen_cyc[4] - ack_edge[3], SET + 1);
        chk("R7 data", int'(data_o), 16'h5555);
    endtask

    task automatic t_timeout;
        int n, d, e;
        resp_en = 1'b0; nreads = 0;
        go(1'b0, 1'b0, 1'b1, 20'h00001, 10);
        wait_end(100, n, d, e);
        chk("R9 error", e, 1);
        chk("R9 no done", d, 0);
        chk("R9 timing", n, 11);
        @(negedge clk);
        chk("R11 error one cycle", int'(error_o), 0);
        chk("R11 idle after error", int'(busy_o), 0);
    endtask

    task automatic t_race(input int tmo, input int want_done);
        int n, d, e;
        logic [DW-1:0] w [8];
        w = '{16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080};
        load_resp(w); resp_en = 1'b1;
        go(1'b0, 1'b0, 1'b1, 20'h00400, tmo);
        wait_end(100, n, d, e);
        chk("R10 outcome done", d, want_done);
        chk("R10 outcome error", e, 1 - want_done);
    endtask

    task automatic t_ready;
        int n, d, e;
        logic [DW-1:0] w [8];
        w = '{16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF};
        load_resp(w); resp_en = 1'b1; ready_i = 1'b0;
        go(1'b0, 1'b1, 1'b0, 20'h00777, 60);
        repeat (5) @(negedge clk);
        start_i = 1'b1; use_rdy_i = 1'b0;   // ignored while busy
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 no reads while waiting", nreads, 0);
        chk("R11 busy kept", int'(busy_o), 1);
        chk("R8 no early done", int'(done_o), 0);
        ready_i = 1'b1;
        wait_end(8, n, d, e);
        chk("R8 done after ready", d, 1);
        chk("R8 single fetch", nreads, 1);
        chk("R8 data", int'(data_o), 16'hBEEF);
        ready_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ready_timeout;
        int n, d, e;
        resp_en = 1'b1; nreads = 0; ready_i = 1'b0;
        go(1'b0, 1'b1, 1'b0, 20'h00002, 5);
        wait_end(50, n, d, e);
        chk("R9 ready error", e, 1);
        chk("R9 ready timing", n, 6);
        chk("R8 no reads", nreads, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program_exp1();
        t_erase();
        t_program_exp0();
        t_timeout();
        t_race(4, 1);
        repeat (2) @(negedge clk);
        t_race(3, 0);
        t_ready();
        t_ready_timeout();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule